// File: doc/BRIEF.md
# Fractional Bit-Rate Tick Generator

This block turns a fast peripheral clock into a single-cycle enable pulse at a serial bit rate. It divides in two stages. A power-of-two prescaler produces a base step of 2^(7-S) clock cycles, where S is a three-bit scale select. A period counter then counts W of those base steps, where W is the integer part of the divisor. A seven-bit fraction F adds the missing part in 1/128 steps. The fraction is summed once per bit period, and each time the sum carries past 128 that bit period lasts one extra base step.

Software picks the largest S for which the ideal divisor, clock / (2^(7-S) × bit rate), is at least 1. W is the integer part of that divisor, and F is its remainder multiplied by 128. For example, a 48 MHz clock with a 1,843,200 bit/s target uses S = 7, W = 26 and F = 5. Any change to the fields restarts the generator cleanly, so a new bit rate takes effect at once.

Top module: `fbg_bitrate_gen`

## Requirements
- R1: While reset is high, the tick output stays low. After reset is released, with the fields held, the first tick arrives exactly L×P cycles later, where P = 2^(7-S) and L is the length of the first bit period.
- R2: The base step is P = 2^(7-S) clock cycles. S = 7 gives 1 cycle and S = 0 gives 128 cycles. Every tick falls on the last cycle of a base step.
- R3: When F = 0, every bit period lasts exactly W×P cycles.
- R4: Bit period k after a restart (k = 1, 2, ...) lasts (W + floor(k×F/128) − floor((k−1)×F/128)) × P cycles. Over 128 periods the total is exactly P×(128×W + F) cycles.
- R5: A value of 0 in the integer field behaves exactly like a value of 1.
- R6: A change to any of S, W or F in a cycle restarts the generator. The prescaler, the period counter and the fraction sum all return to zero, no tick is issued in the cycle after the change, and the first tick under the new fields comes L×P clock edges after the edge that sees the change.
- R7: Each tick is high for one clock cycle. Two ticks are back to back only when the bit period is itself one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| scale_sel | input | 3 | Power-of-two prescale select S; base step is 2^(7-S) cycles |
| whole_div | input | 12 | Integer divisor W in base steps (0 acts as 1) |
| frac_div | input | 7 | Fractional divisor F in units of 1/128 base step |
| bit_tick | output | 1 | One-cycle pulse at the bit rate |

## Verification
Some properties are checked on every cycle. The prescaler and period counter never pass their programmed terminal counts. A tick only follows a base-step boundary, and a restart is never followed by a tick. The fraction sum changes only at the end of a bit period or on a restart. Other behaviour needs the bench's scenarios to show it. These are the exact length of each bit period, the pattern of which periods are stretched, the exact 128-period total against the ideal divisor, the timing of the first tick after a field change in the middle of a period, and the equivalence of an integer field of 0 and 1.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  // default field widths shared by the generator and its checker
  localparam int unsigned SCALE_W = 3;
  localparam int unsigned WHOLE_W = 12;
  localparam int unsigned FRAC_W  = 7;
endpackage

// File: rtl/fbg_prescaler.sv
module fbg_prescaler #(
  parameter int unsigned SCALE_W = fbg_pkg::SCALE_W,
  localparam int unsigned PRE_W  = (1 << SCALE_W) - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic [SCALE_W-1:0] scale_sel,
  output logic               step_end,
  output logic [PRE_W-1:0]   pre_cnt
);
  // terminal count of the base step: 2^(PRE_W - sel) - 1, as a mask
  function automatic logic [PRE_W-1:0] step_last(input logic [SCALE_W-1:0] sel);
    return {PRE_W{1'b1}} >> sel;
  endfunction

  assign step_end = (pre_cnt == step_last(scale_sel));

  always_ff @(posedge clk) begin
    if (rst || restart)  pre_cnt <= '0;
    else if (step_end)   pre_cnt <= '0;
    else                 pre_cnt <= pre_cnt + 1'b1;
  end
endmodule

// File: rtl/fbg_frac_accum.sv
module fbg_frac_accum #(
  parameter int unsigned FRAC_W = fbg_pkg::FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              advance,
  input  logic [FRAC_W-1:0] frac_div,
  output logic              stretch,
  output logic [FRAC_W-1:0] acc
);
  // sum for the current period; its carry lengthens this period
  function automatic logic [FRAC_W:0] frac_sum(input logic [FRAC_W-1:0] a,
                                              input logic [FRAC_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  logic [FRAC_W:0] sum_w;
  assign sum_w   = frac_sum(acc, frac_div);
  assign stretch = sum_w[FRAC_W];

  always_ff @(posedge clk) begin
    if (rst || restart) acc <= '0;
    else if (advance)   acc <= sum_w[FRAC_W-1:0];
  end
endmodule

// File: rtl/fbg_period_counter.sv
module fbg_period_counter #(
  parameter int unsigned WHOLE_W = fbg_pkg::WHOLE_W,
  localparam int unsigned CNT_W  = WHOLE_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic               step_end,
  input  logic [WHOLE_W-1:0] whole_div,
  input  logic               stretch,
  output logic               period_end,
  output logic [CNT_W-1:0]   per_cnt
);
  // integer field with 0 promoted to 1
  function automatic logic [CNT_W-1:0] eff_whole(input logic [WHOLE_W-1:0] w);
    return (w == '0) ? CNT_W'(1) : {1'b0, w};
  endfunction

  logic [CNT_W-1:0] last_idx;
  assign last_idx   = eff_whole(whole_div) - CNT_W'(1) + CNT_W'(stretch);
  assign period_end = step_end && (per_cnt == last_idx);

  always_ff @(posedge clk) begin
    if (rst || restart)  per_cnt <= '0;
    else if (period_end) per_cnt <= '0;
    else if (step_end)   per_cnt <= per_cnt + 1'b1;
  end
endmodule

// File: rtl/fbg_bitrate_gen.sv
module fbg_bitrate_gen #(
  parameter int unsigned SCALE_W = fbg_pkg::SCALE_W,
  parameter int unsigned WHOLE_W = fbg_pkg::WHOLE_W,
  parameter int unsigned FRAC_W  = fbg_pkg::FRAC_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SCALE_W-1:0] scale_sel,
  input  logic [WHOLE_W-1:0] whole_div,
  input  logic [FRAC_W-1:0]  frac_div,
  output logic               bit_tick
);
  localparam int unsigned PRE_W = (1 << SCALE_W) - 1;
  localparam int unsigned CNT_W = WHOLE_W + 1;
  localparam int unsigned CFG_W = SCALE_W + WHOLE_W + FRAC_W;

  // named internal events, also observed by the bound checker
  logic             restart_w;
  logic             step_end_w;
  logic             period_end_w;
  logic             stretch_w;
  logic [PRE_W-1:0] pre_cnt_w;
  logic [CNT_W-1:0] per_cnt_w;
  logic [FRAC_W-1:0] acc_w;

  logic [CFG_W-1:0] cfg_now, cfg_prev;
  assign cfg_now   = {scale_sel, whole_div, frac_div};
  assign restart_w = (cfg_now != cfg_prev);

  always_ff @(posedge clk) begin
    cfg_prev <= cfg_now;
    if (rst) bit_tick <= 1'b0;
    else     bit_tick <= period_end_w && !restart_w;
  end

  fbg_prescaler #(.SCALE_W(SCALE_W)) u_pre (
    .clk(clk), .rst(rst), .restart(restart_w), .scale_sel(scale_sel),
    .step_end(step_end_w), .pre_cnt(pre_cnt_w)
  );

  fbg_frac_accum #(.FRAC_W(FRAC_W)) u_frac (
    .clk(clk), .rst(rst), .restart(restart_w), .advance(period_end_w),
    .frac_div(frac_div), .stretch(stretch_w), .acc(acc_w)
  );

  fbg_period_counter #(.WHOLE_W(WHOLE_W)) u_per (
    .clk(clk), .rst(rst), .restart(restart_w), .step_end(step_end_w),
    .whole_div(whole_div), .stretch(stretch_w),
    .period_end(period_end_w), .per_cnt(per_cnt_w)
  );
endmodule

// File: rtl/fbg_bitrate_gen_chk.sv
module fbg_bitrate_gen_chk #(
  parameter int unsigned SCALE_W = fbg_pkg::SCALE_W,
  parameter int unsigned WHOLE_W = fbg_pkg::WHOLE_W,
  parameter int unsigned FRAC_W  = fbg_pkg::FRAC_W,
  localparam int unsigned PRE_W  = (1 << SCALE_W) - 1,
  localparam int unsigned CNT_W  = WHOLE_W + 1
) (
  input logic               clk,
  input logic               rst,
  input logic [SCALE_W-1:0] scale_sel,
  input logic [WHOLE_W-1:0] whole_div,
  input logic               bit_tick,
  input logic               restart_w,
  input logic               step_end_w,
  input logic               period_end_w,
  input logic [PRE_W-1:0]   pre_cnt_w,
  input logic [CNT_W-1:0]   per_cnt_w,
  input logic [FRAC_W-1:0]  acc_w
);
  logic [PRE_W-1:0] pre_lim;
  logic [CNT_W-1:0] per_lim;
  assign pre_lim = {PRE_W{1'b1}} >> scale_sel;
  assign per_lim = (whole_div == '0) ? CNT_W'(1) : {1'b0, whole_div};

  // R2
  tick_on_step_chk: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> $past(step_end_w));

  // R6
  restart_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    restart_w |=> !bit_tick);

  // R2
  pre_bound_chk: assert property (@(posedge clk) disable iff (rst)
    !restart_w |-> (pre_cnt_w <= pre_lim));

  // R5
  per_bound_chk: assert property (@(posedge clk) disable iff (rst)
    !restart_w |-> (per_cnt_w <= per_lim));

  // R4
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!period_end_w && !restart_w) |=> $stable(acc_w));
endmodule

bind fbg_bitrate_gen fbg_bitrate_gen_chk #(
  .SCALE_W(SCALE_W), .WHOLE_W(WHOLE_W), .FRAC_W(FRAC_W)
) u_chk (
  .clk(clk), .rst(rst), .scale_sel(scale_sel), .whole_div(whole_div),
  .bit_tick(bit_tick), .restart_w(restart_w), .step_end_w(step_end_w),
  .period_end_w(period_end_w), .pre_cnt_w(pre_cnt_w),
  .per_cnt_w(per_cnt_w), .acc_w(acc_w)
);

// File: tb/sim_fbg_bitrate_gen.sv
module sim_fbg_bitrate_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  scale_sel = 3'd7;
  logic [11:0] whole_div = 12'd3;
  logic [6:0]  frac_div  = 7'd0;
  logic        bit_tick;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  fbg_bitrate_gen u0 (
    .clk(clk), .rst(rst), .scale_sel(scale_sel), .whole_div(whole_div),
    .frac_div(frac_div), .bit_tick(bit_tick)
  );

  // {scale_sel, whole_div, frac_div}
  localparam logic [21:0] VECS [7] = '{
    {3'd7, 12'd26, 7'd5},
    {3'd5, 12'd3,  7'd100},
    {3'd0, 12'd1,  7'd1},
    {3'd6, 12'd0,  7'd0},
    {3'd4, 12'd5,  7'd64},
    {3'd7, 12'd1,  7'd127},
    {3'd3, 12'd2,  7'd0}
  };

  function automatic string vec_tag(input int i);
    case (i)
      1, 2:    return "R2";
      3:       return "R5";
      5:       return "R7";
      6:       return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // apply fields at a falling edge and check each of nper bit periods
  task automatic run_vec(input logic [2:0] s, input logic [11:0] w,
                         input logic [6:0] f, input int nper, input string tag);
    int p     = 1 << (7 - int'(s));
    int e     = (w == 0) ? 1 : int'(w);
    int fi    = int'(f);
    int total = 0;
    @(negedge clk);
    scale_sel = s; whole_div = w; frac_div = f;
    for (int k = 1; k <= nper; k++) begin
      int extra = ((k * fi) >> 7) - (((k - 1) * fi) >> 7);
      int exp   = (e + extra) * p + ((k == 1) ? 1 : 0);
      int cnt   = 0;
      do begin
        @(negedge clk);
        cnt++;
      end while (!bit_tick && cnt <= exp + 8);
      check(cnt == exp, (k == 1) ? {tag, " R6 first period"} : {tag, " R4 period"}, cnt, exp);
      total += cnt;
    end
    if (nper == 128)
      check(total - 1 == p * (128 * e + fi), {tag, " R4 128-period total"},
            total - 1, p * (128 * e + fi));
  endtask

  initial begin
    #(20 * 190000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1: quiet under reset, then the first tick after W*P cycles
    repeat (4) @(negedge clk);
    check(bit_tick == 1'b0, "R1 reset low", int'(bit_tick), 0);
    rst = 1'b0;
    begin
      int cnt = 0;
      do begin
        @(negedge clk);
        cnt++;
      end while (!bit_tick && cnt < 20);
      check(cnt == 3, "R1 first tick after reset", cnt, 3);
      @(negedge clk);
      check(bit_tick == 1'b0, "R7 single-cycle tick", int'(bit_tick), 0);
    end

    for (int i = 0; i < 7; i++)
      run_vec(VECS[i][21:19], VECS[i][18:7], VECS[i][6:0], 128, vec_tag(i));

    // R6: change the fields in the middle of a long period
    @(negedge clk);
    scale_sel = 3'd2; whole_div = 12'd40; frac_div = 7'd0;
    repeat (50) @(negedge clk);
    run_vec(3'd6, 12'd3, 7'd33, 6, "R6");

    // R5: integer field 0 and 1 give the same periods
    run_vec(3'd7, 12'd0, 7'd90, 8, "R5");
    run_vec(3'd7, 12'd1, 7'd90, 8, "R5");

    // R1: reset in the middle of operation clears state
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(bit_tick == 1'b0, "R1 reset low again", int'(bit_tick), 0);
    scale_sel = 3'd6; whole_div = 12'd4; frac_div = 7'd0;
    @(negedge clk);
    rst = 1'b0;
    begin
      int cnt = 0;
      do begin
        @(negedge clk);
        cnt++;
      end while (!bit_tick && cnt < 40);
      check(cnt == 8, "R1 R2 first tick after second reset", cnt, 8);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule